// File: doc/BRIEF.md
# Oversampled Serial Receiver with Sticky Status Flags

This block receives asynchronous serial frames from a single RX line. The line is sampled at sixteen times the bit rate, and that rate is set by an external tick strobe. A start bit is found on a falling edge and confirmed at its middle. The eight data bits then follow, least significant bit first. An optional parity bit comes next, and the frame ends with one stop bit. A completed byte is moved into a data register, and two sticky status flags report the result.

Software reads both registers and clears the flags through a small bus. A flag clears only when 0 is written to it after it has been read as 1. When a frame fails its parity check, the byte is still stored, but only the error flag is raised. The receiver then takes no further frames until software clears that flag. A standby input clears the error flag. Dropping the receive enable stops reception and leaves the error flag as it was.

Top module: `serial_rx_stat`

## Requirements
- R1: After reset the data register reads 0x00 and the status register reads 0x00.
- R2: The data register is at bus address 0 and the status register is at bus address 1. In the status register, bit 0 is the data-full flag and bit 1 is the parity-error flag. A valid frame carries eight data bits, least significant bit first. It stores the byte in the data register and sets the data-full flag.
- R3: When parity is enabled, one parity bit follows the data bits. With the odd control at 1, a frame is correct when data plus parity hold an odd number of ones; with the odd control at 0, the count must be even. A mismatch sets the parity-error flag.
- R4: A frame that fails its parity check still stores its byte in the data register, and it leaves the data-full flag unchanged.
- R5: While the parity-error flag is 1, frames on the line are ignored: the data register and the data-full flag keep their values.
- R6: Writing 0 to a flag clears it only when that flag was read as 1 since it was last cleared. A write of 0 without such a read leaves the flag at 1.
- R7: Writing 1 to either flag bit never sets it.
- R8: The standby input clears the parity-error flag and cancels any read that armed it. After the flag is set again, a write of 0 without a new read leaves it at 1.
- R9: While receive enable is 0, no frame is received, and the parity-error flag keeps its value.
- R10: Reading the data register does not clear the data-full flag.
- R11: A frame whose stop bit is sampled as 0 is discarded: the data register and both flags are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| standby_i | input | 1 | Standby request; clears the parity-error flag and halts the receiver |
| os_tick_i | input | 1 | One-cycle strobe at sixteen times the bit rate |
| rx_i | input | 1 | Serial receive line, idle high |
| rx_en_i | input | 1 | Receive enable |
| par_en_i | input | 1 | Parity bit present in each frame |
| par_odd_i | input | 1 | 1 selects odd parity, 0 selects even parity |
| bus_rd_i | input | 1 | Register read strobe |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 1 | Register select: 0 data, 1 status |
| bus_wdata_i | input | 2 | Write data for the two status flag bits |
| bus_rdata_o | output | 8 | Read data for the selected register |

## Verification
The assertions assume that each bus access lasts exactly one cycle and that read and write are never asserted in the same cycle. They also assume that the RX line changes only at whole-bit boundaries of sixteen ticks, so every mid-bit sample reads a settled level. The bench drives the strobes for one cycle each through separate tasks. It holds every bit on the line for exactly sixteen tick periods and leaves at least two idle bit times between frames. This keeps the start-edge search and the flag updates inside the conditions the properties rely on.

// File: rtl/srx_pkg.sv
package srx_pkg;

    localparam int unsigned DATA_W    = 8;
    localparam int unsigned NFLAG     = 2;
    localparam int unsigned FLAG_FULL = 0;
    localparam int unsigned FLAG_PERR = 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } rx_state_e;

    typedef enum logic {
        REG_DATA = 1'b0,
        REG_STAT = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              par_bad;
    } rx_frame_t;

    // ones_xor is the XOR of all data and parity bits; odd_sel picks odd parity
    function automatic logic parity_wrong(input logic ones_xor, input logic odd_sel);
        return ones_xor ^ odd_sel;
    endfunction

endpackage

// File: rtl/srx_sampler.sv
module srx_sampler
    import srx_pkg::*;
#(
    parameter int unsigned OS_RATE = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      abort_i,
    input  logic      hold_i,
    input  logic      tick_i,
    input  logic      rx_i,
    input  logic      par_en_i,
    input  logic      par_odd_i,
    output logic      done_o,
    output rx_frame_t frame_o
);
    localparam int unsigned CW  = $clog2(OS_RATE);
    localparam int unsigned BW  = $clog2(DATA_W);
    localparam logic [CW-1:0] MID_CNT  = CW'(OS_RATE / 2 - 1);
    localparam logic [CW-1:0] LAST_CNT = CW'(OS_RATE - 1);
    localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

    rx_state_e         state_q;
    logic [CW-1:0]     cnt_q;
    logic [BW-1:0]     idx_q;
    logic [DATA_W-1:0] shreg_q;
    logic              par_q;
    logic              line_q;
    logic              done_q;
    logic              bad_q;

    always_ff @(posedge clk) begin
        if (rst || abort_i) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            shreg_q <= '0;
            par_q   <= 1'b0;
            line_q  <= 1'b1;
            done_q  <= 1'b0;
            bad_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (tick_i) begin
                line_q <= rx_i;
                unique case (state_q)
                    ST_IDLE: begin
                        if (!hold_i && line_q && !rx_i) begin
                            state_q <= ST_START;
                            cnt_q   <= CW'(1);
                        end
                    end
                    ST_START: begin
                        if (cnt_q == MID_CNT) begin
                            cnt_q   <= '0;
                            idx_q   <= '0;
                            state_q <= rx_i ? ST_IDLE : ST_DATA;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_DATA: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q   <= '0;
                            shreg_q <= {rx_i, shreg_q[DATA_W-1:1]};
                            if (idx_q == LAST_BIT) begin
                                idx_q   <= '0;
                                state_q <= par_en_i ? ST_PAR : ST_STOP;
                            end else begin
                                idx_q <= idx_q + BW'(1);
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_PAR: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q   <= '0;
                            par_q   <= rx_i;
                            state_q <= ST_STOP;
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    ST_STOP: begin
                        if (cnt_q == LAST_CNT) begin
                            cnt_q   <= '0;
                            state_q <= ST_IDLE;
                            if (rx_i) begin
                                done_q <= 1'b1;
                                bad_q  <= par_en_i &&
                                          parity_wrong((^shreg_q) ^ par_q, par_odd_i);
                            end
                        end else begin
                            cnt_q <= cnt_q + CW'(1);
                        end
                    end
                    default: state_q <= ST_IDLE;
                endcase
            end
        end
    end

    assign done_o          = done_q;
    assign frame_o.data    = shreg_q;
    assign frame_o.par_bad = bad_q;

endmodule

// File: rtl/srx_flag_bit.sv
module srx_flag_bit #(
    parameter bit STBY_CLR = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic standby_i,
    input  logic set_i,
    input  logic rd_i,
    input  logic wr_i,
    input  logic wbit_i,
    output logic flag_o,
    output logic arm_o
);
    logic flag_q;
    logic arm_q;
    logic clr_w;

    assign clr_w = wr_i && !wbit_i && arm_q;

    always_ff @(posedge clk) begin
        if (rst || (STBY_CLR && standby_i)) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else begin
            flag_q <= set_i || (flag_q && !clr_w);
            arm_q  <= clr_w ? 1'b0 : (arm_q || (rd_i && flag_q));
        end
    end

    assign flag_o = flag_q;
    assign arm_o  = arm_q;

endmodule

// File: rtl/serial_rx_stat.sv
module serial_rx_stat
    import srx_pkg::*;
#(
    parameter int unsigned OS_RATE = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       standby_i,
    input  logic       os_tick_i,
    input  logic       rx_i,
    input  logic       rx_en_i,
    input  logic       par_en_i,
    input  logic       par_odd_i,
    input  logic       bus_rd_i,
    input  logic       bus_wr_i,
    input  logic       bus_addr_i,
    input  logic [1:0] bus_wdata_i,
    output logic [7:0] bus_rdata_o
);
    logic              done_w;
    rx_frame_t         frame_w;
    logic [NFLAG-1:0]  set_w;
    logic [NFLAG-1:0]  flag_w;
    logic [NFLAG-1:0]  arm_w;
    logic              rd_stat_w;
    logic              wr_stat_w;
    logic [DATA_W-1:0] data_q;

    assign rd_stat_w = bus_rd_i && (reg_sel_e'(bus_addr_i) == REG_STAT);
    assign wr_stat_w = bus_wr_i && (reg_sel_e'(bus_addr_i) == REG_STAT);

    srx_sampler #(.OS_RATE(OS_RATE)) sampler_i (
        .clk       (clk),
        .rst       (rst),
        .abort_i   (!rx_en_i || standby_i),
        .hold_i    (flag_w[FLAG_PERR]),
        .tick_i    (os_tick_i),
        .rx_i      (rx_i),
        .par_en_i  (par_en_i),
        .par_odd_i (par_odd_i),
        .done_o    (done_w),
        .frame_o   (frame_w)
    );

    assign set_w[FLAG_FULL] = done_w && !frame_w.par_bad;
    assign set_w[FLAG_PERR] = done_w &&  frame_w.par_bad;

    for (genvar g = 0; g < NFLAG; g++) begin : g_flag
        srx_flag_bit #(.STBY_CLR(g == FLAG_PERR)) flag_i (
            .clk       (clk),
            .rst       (rst),
            .standby_i (standby_i),
            .set_i     (set_w[g]),
            .rd_i      (rd_stat_w),
            .wr_i      (wr_stat_w),
            .wbit_i    (bus_wdata_i[g]),
            .flag_o    (flag_w[g]),
            .arm_o     (arm_w[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= '0;
        end else if (done_w) begin
            data_q <= frame_w.data;
        end
    end

    always_comb begin
        if (reg_sel_e'(bus_addr_i) == REG_DATA) begin
            bus_rdata_o = data_q;
        end else begin
            bus_rdata_o = {{(DATA_W - NFLAG){1'b0}}, flag_w};
        end
    end

endmodule

// File: rtl/srx_checker.sv
module srx_checker
    import srx_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             standby,
    input logic             done,
    input logic             par_bad,
    input logic [NFLAG-1:0] flag,
    input logic [NFLAG-1:0] arm
);
    assert_bad_keeps_full_R4: assert property (@(posedge clk) disable iff (rst)
        (done && par_bad && !flag[FLAG_FULL]) |=> !flag[FLAG_FULL]);

    assert_bad_sets_perr_R3: assert property (@(posedge clk) disable iff (rst)
        (done && par_bad && !standby) |=> flag[FLAG_PERR]);

    assert_perr_blocks_rx_R5: assert property (@(posedge clk) disable iff (rst)
        flag[FLAG_PERR] |-> !done);

    assert_full_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
        (flag[FLAG_FULL] && !arm[FLAG_FULL]) |=> flag[FLAG_FULL]);

    assert_perr_needs_arm_R6: assert property (@(posedge clk) disable iff (rst)
        (flag[FLAG_PERR] && !arm[FLAG_PERR] && !standby) |=> flag[FLAG_PERR]);

    assert_full_no_wset_R7: assert property (@(posedge clk) disable iff (rst)
        (!flag[FLAG_FULL] && !done) |=> !flag[FLAG_FULL]);

    assert_perr_no_wset_R7: assert property (@(posedge clk) disable iff (rst)
        (!flag[FLAG_PERR] && !done) |=> !flag[FLAG_PERR]);

    assert_standby_clears_R8: assert property (@(posedge clk) disable iff (rst)
        standby |=> (!flag[FLAG_PERR] && !arm[FLAG_PERR]));

endmodule

bind serial_rx_stat srx_checker chk_i (
    .clk     (clk),
    .rst     (rst),
    .standby (standby_i),
    .done    (done_w),
    .par_bad (frame_w.par_bad),
    .flag    (flag_w),
    .arm     (arm_w)
);

// File: tb/serial_rx_stat_tb_top.sv
module serial_rx_stat_tb_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       standby = 1'b0;
    logic       tick = 1'b0;
    logic       rx = 1'b1;
    logic       rx_en = 1'b1;
    logic       par_en = 1'b0;
    logic       par_odd = 1'b0;
    logic       rd = 1'b0;
    logic       wr = 1'b0;
    logic       addr = 1'b0;
    logic [1:0] wdata = 2'b00;
    logic [7:0] rdata;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [7:0] last_data = 8'h00;

    serial_rx_stat dut_i (
        .clk         (clk),
        .rst         (rst),
        .standby_i   (standby),
        .os_tick_i   (tick),
        .rx_i        (rx),
        .rx_en_i     (rx_en),
        .par_en_i    (par_en),
        .par_odd_i   (par_odd),
        .bus_rd_i    (rd),
        .bus_wr_i    (wr),
        .bus_addr_i  (addr),
        .bus_wdata_i (wdata),
        .bus_rdata_o (rdata)
    );

    always #4 clk = ~clk;

    // tick strobe every second clock: one bit = 16 ticks = 32 clocks
    initial begin
        forever begin
            @(negedge clk);
            tick <= ~tick;
        end
    end

    // vector fields: data[12:5] par_en[4] odd[3] flip[2] exp_full[1] exp_perr[0]
    localparam logic [12:0] VECS [6] = '{
        {8'hA5, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h3C, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0},
        {8'h01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0},
        {8'h7E, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {8'hFF, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {8'h80, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        rx <= b;
        repeat (32) @(negedge clk);
    endtask

    task automatic send_frame(input logic [7:0] d, input logic pen,
                              input logic pbit, input logic stopb);
        send_bit(1'b0);
        for (int i = 0; i < 8; i++) send_bit(d[i]);
        if (pen) send_bit(pbit);
        send_bit(stopb);
        send_bit(1'b1);
        send_bit(1'b1);
    endtask

    task automatic bus_read(input logic a, output logic [7:0] v);
        @(negedge clk);
        addr <= a;
        rd   <= 1'b1;
        #1 v = rdata;
        @(negedge clk);
        rd <= 1'b0;
    endtask

    task automatic bus_write(input logic a, input logic [1:0] v);
        @(negedge clk);
        addr  <= a;
        wdata <= v;
        wr    <= 1'b1;
        @(negedge clk);
        wr <= 1'b0;
    endtask

    task automatic clear_flags();
        logic [7:0] v;
        bus_read(1'b1, v);
        bus_write(1'b1, 2'b00);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst <= 1'b0;
        repeat (4) @(negedge clk);

        // R1 reset state
        bus_read(1'b0, v);
        check("R1 data", v, 8'h00);
        bus_read(1'b1, v);
        check("R1 status", v, 8'h00);

        // R2 R3 R4 vector table
        for (int i = 0; i < 6; i++) begin
            logic [7:0] d;
            logic       pb;
            d       = VECS[i][12:5];
            par_en  <= VECS[i][4];
            par_odd <= VECS[i][3];
            pb      = (^d) ^ VECS[i][3] ^ VECS[i][2];
            send_frame(d, VECS[i][4], pb, 1'b1);
            last_data = d;
            bus_read(1'b0, v);
            check("R2/R4 data", v, d);
            bus_read(1'b1, v);
            check("R2/R3 status", v, {6'b0, VECS[i][0], VECS[i][1]});
            bus_write(1'b1, 2'b00);
            bus_read(1'b1, v);
            check("R6 cleared", v, 8'h00);
        end

        par_en <= 1'b1;
        par_odd <= 1'b0;

        // R10 data read keeps full
        send_frame(8'h5A, 1'b1, 1'b0, 1'b1);
        last_data = 8'h5A;
        bus_read(1'b0, v);
        bus_read(1'b0, v);
        bus_read(1'b1, v);
        check("R10 full kept", v, 8'h01);
        bus_write(1'b1, 2'b00);

        // R6 write 0 without arming read
        send_frame(8'h0F, 1'b1, 1'b0, 1'b1);
        last_data = 8'h0F;
        bus_write(1'b1, 2'b00);
        bus_read(1'b1, v);
        check("R6 unarmed", v, 8'h01);
        bus_write(1'b1, 2'b00);
        bus_read(1'b1, v);
        check("R6 armed clear", v, 8'h00);

        // R7 writing 1 never sets
        bus_write(1'b1, 2'b11);
        bus_read(1'b1, v);
        check("R7 write one", v, 8'h00);

        // R5 reception stalls while parity error set
        send_frame(8'h7E, 1'b1, 1'b1, 1'b1);
        last_data = 8'h7E;
        send_frame(8'h55, 1'b1, 1'b0, 1'b1);
        bus_read(1'b0, v);
        check("R5 data held", v, last_data);
        bus_read(1'b1, v);
        check("R5 status", v, 8'h02);

        // R9 receive enable low keeps parity error
        rx_en <= 1'b0;
        repeat (40) @(negedge clk);
        bus_read(1'b1, v);
        check("R9 perr kept", v, 8'h02);

        // R8 standby clears and disarms
        @(negedge clk);
        standby <= 1'b1;
        @(negedge clk);
        standby <= 1'b0;
        bus_read(1'b1, v);
        check("R8 standby clear", v, 8'h00);
        rx_en <= 1'b1;
        repeat (4) @(negedge clk);
        send_frame(8'hC3, 1'b1, 1'b1, 1'b1);
        last_data = 8'hC3;
        bus_write(1'b1, 2'b00);
        bus_read(1'b1, v);
        check("R8 arm dropped", v, 8'h02);
        bus_write(1'b1, 2'b00);
        bus_read(1'b1, v);
        check("R8 rearmed clear", v, 8'h00);

        // R9 disabled receiver takes no frame
        rx_en <= 1'b0;
        send_frame(8'h33, 1'b1, 1'b0, 1'b1);
        bus_read(1'b0, v);
        check("R9 data", v, last_data);
        bus_read(1'b1, v);
        check("R9 status", v, 8'h00);
        rx_en <= 1'b1;
        repeat (4) @(negedge clk);

        // R11 bad stop bit discards the frame
        send_frame(8'h99, 1'b1, 1'b0, 1'b0);
        bus_read(1'b0, v);
        check("R11 data", v, last_data);
        bus_read(1'b1, v);
        check("R11 status", v, 8'h00);

        // R2 recovery with odd parity
        par_odd <= 1'b1;
        send_frame(8'h96, 1'b1, 1'b1, 1'b1);
        bus_read(1'b0, v);
        check("R2 recover data", v, 8'h96);
        bus_read(1'b1, v);
        check("R2 recover status", v, 8'h01);
        clear_flags();

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule